// File: doc/BRIEF.md
# External Edge/Level Interrupt Detector

This block watches a set of external interrupt lines (two by default) and turns activity on them into interrupt requests and a wake request. Each line has a two-bit sense-control field that selects one of four triggers: low level, any logical change, falling edge or rising edge. Each line also has an enable bit and, for the edge triggers, a sticky flag. Software clears a flag by writing one to it, or the interrupt controller clears it when it takes the request.

Edge recognition uses a synchronizer followed by a previous-value register. It runs only while the I/O clock is active. While that clock is halted the edge path holds still. Once the clock returns, the edge path stays blind until both samples it compares were taken with the clock running. Low-level triggering is also available without the clock: while the clock is halted, or while the synchronizer refills, the request and the wake request come straight from the raw pin. A level request is never stored. It lasts exactly as long as the line is low. The detector sees the pin value whatever drives the pin, so software can raise an interrupt by driving the pin itself.

Top module: `exti_detector`

## Requirements
- R1: With sense 00 (low level) and the line enabled, the line's request is high while the synchronized pin is low and falls when the pin returns high, with no clear needed. The synchronized pin is the pin sampled two clock edges earlier.
- R2: With sense 10 (falling edge), a 1-to-0 change of the pin sampled at clock edge k sets the line's flag at edge k+2. A 0-to-1 change sets nothing.
- R3: With sense 11 (rising edge), a 0-to-1 change of the pin sampled at edge k sets the flag at edge k+2. A 1-to-0 change sets nothing.
- R4: With sense 01 (any change), a change of the pin in either direction sets the flag at edge k+2.
- R5: A flag stays set until its clear input is high at a clock edge. If a set and a clear fall on the same edge, the set wins.
- R6: In the edge modes the request equals flag AND enable. The flag still sets while the line is disabled, so enabling the line later presents the pending request.
- R7: While the I/O-clock-active input is low, no flag is set. After that input goes high again, an edge is recognised only at the fourth consecutive clocked edge or later. A change that happened while the clock was halted therefore raises nothing.
- R8: With sense 00 and the line enabled, when the I/O clock is halted or the synchronizer has seen fewer than three consecutive clocked edges, the request follows the inverted raw pin with no clock involved.
- R9: The wake output is high when any request is high, or when any enabled line in sense 00 has its raw pin low.
- R10: Reset clears every flag and the synchronizer history. With all pins high, every request and the wake output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | I/O clock domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_clk_on_i | input | 1 | High while the I/O clock is running |
| pin_i | input | NUM_LINES | Raw external interrupt pins |
| sense_i | input | 2*NUM_LINES | Sense-control field per line; line n uses bits [2n+1:2n] |
| en_i | input | NUM_LINES | Per-line interrupt enable |
| clr_i | input | NUM_LINES | Per-line flag clear (write-one or acknowledge) |
| irq_o | output | NUM_LINES | Per-line interrupt request |
| wake_o | output | 1 | Wake request to the power controller |

## Verification
The hardest situation to reach is the return of the I/O clock. A pin that changed while the clock was halted must raise nothing. A pin that changes on the first cycles after the restart must be judged against freshly taken samples only. The stimulus toggles the pins while the clock-active input is low. It also flips pins on the very cycles around the restart, in every sense mode, and a pseudo-random phase gates the clock-active input on and off at irregular intervals. A reference model that keeps only the samples taken since the last restart is compared with the design on every cycle.

// File: rtl/exti_pkg.sv
package exti_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    // Decide whether a pair of consecutive samples matches the sense mode.
    function automatic logic edge_hit(sense_e mode, logic cur, logic old);
        logic hit;
        case (mode)
            SENSE_ANY:  hit = cur ^ old;
            SENSE_FALL: hit = old & ~cur;
            SENSE_RISE: hit = cur & ~old;
            default:    hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/exti_sampler.sv
module exti_sampler #(
    parameter int N_SYNC = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic io_on_i,
    input  logic pin_i,
    output logic cur_o,
    output logic old_o,
    output logic armed_o
);
    localparam int ARM_CNT = N_SYNC + 1;
    localparam int CW      = $clog2(ARM_CNT + 1);

    typedef struct packed {
        logic [N_SYNC-1:0] chain;
        logic              old;
        logic [CW-1:0]     cnt;
    } smp_t;

    smp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (io_on_i) begin
            st_d.chain = {st_q.chain[N_SYNC-2:0], pin_i};
            st_d.old   = st_q.chain[N_SYNC-1];
            if (st_q.cnt != CW'(ARM_CNT)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            // Clock halted: samples freeze and the history is invalidated.
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{chain: '1, old: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_o   = st_q.chain[N_SYNC-1];
    assign old_o   = st_q.old;
    assign armed_o = io_on_i && (st_q.cnt == CW'(ARM_CNT));

endmodule

// File: rtl/exti_flag.sv
module exti_flag
    import exti_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  sense_e sense_i,
    input  logic   en_i,
    input  logic   clr_i,
    input  logic   armed_i,
    input  logic   cur_i,
    input  logic   old_i,
    input  logic   pin_i,
    output logic   irq_o,
    output logic   wake_lvl_o
);
    typedef struct packed {
        logic flag;
    } flg_t;

    flg_t st_d, st_q;
    logic set_evt;
    logic is_level;
    logic low_seen;

    assign is_level = (sense_i == SENSE_LOW);

    always_comb begin
        set_evt   = armed_i && !is_level && edge_hit(sense_i, cur_i, old_i);
        st_d      = st_q;
        // A fresh event outranks a simultaneous clear.
        st_d.flag = set_evt | (st_q.flag & ~clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{flag: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // Synchronized level when history is valid, raw pin otherwise.
    assign low_seen   = armed_i ? ~cur_i : ~pin_i;
    assign irq_o      = en_i & (is_level ? low_seen : st_q.flag);
    assign wake_lvl_o = en_i & is_level & ~pin_i;

endmodule

// File: rtl/exti_detector.sv
module exti_detector
    import exti_pkg::*;
#(
    parameter int NUM_LINES = 2,
    parameter int N_SYNC    = 2
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   io_clk_on_i,
    input  logic [NUM_LINES-1:0]   pin_i,
    input  logic [2*NUM_LINES-1:0] sense_i,
    input  logic [NUM_LINES-1:0]   en_i,
    input  logic [NUM_LINES-1:0]   clr_i,
    output logic [NUM_LINES-1:0]   irq_o,
    output logic                   wake_o
);
    logic [NUM_LINES-1:0] cur, old, armed, wake_lvl;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        exti_sampler #(.N_SYNC(N_SYNC)) u_smp (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .io_on_i (io_clk_on_i),
            .pin_i   (pin_i[g]),
            .cur_o   (cur[g]),
            .old_o   (old[g]),
            .armed_o (armed[g])
        );

        exti_flag u_flg (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .sense_i    (sense_e'(sense_i[2*g +: 2])),
            .en_i       (en_i[g]),
            .clr_i      (clr_i[g]),
            .armed_i    (armed[g]),
            .cur_i      (cur[g]),
            .old_i      (old[g]),
            .pin_i      (pin_i[g]),
            .irq_o      (irq_o[g]),
            .wake_lvl_o (wake_lvl[g])
        );
    end

    assign wake_o = (|irq_o) | (|wake_lvl);

endmodule

// File: rtl/exti_checker.sv
module exti_checker #(
    parameter int NUM_LINES = 2
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   io_clk_on_i,
    input logic [NUM_LINES-1:0]   pin_i,
    input logic [2*NUM_LINES-1:0] sense_i,
    input logic [NUM_LINES-1:0]   en_i,
    input logic [NUM_LINES-1:0]   clr_i,
    input logic [NUM_LINES-1:0]   irq_o,
    input logic                   wake_o
);
    a_r9_wake_covers_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|irq_o) |-> wake_o);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
        logic [1:0] mode;
        assign mode = sense_i[2*g +: 2];

        a_r8_async_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (en_i[g] && mode == 2'b00 && !io_clk_on_i && !pin_i[g]) |-> irq_o[g]);

        a_r6_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !en_i[g] |-> !irq_o[g]);

        a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (irq_o[g] && !clr_i[g] && mode != 2'b00)
            |=> (irq_o[g] || !en_i[g] || sense_i[2*g +: 2] == 2'b00));

        a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i[g] && !io_clk_on_i && mode != 2'b00)
            |=> (!irq_o[g] || sense_i[2*g +: 2] == 2'b00));

        a_r7_halt_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!io_clk_on_i && en_i[g] && !irq_o[g] && mode != 2'b00)
            |=> (!irq_o[g] || sense_i[2*g +: 2] == 2'b00));
    end

endmodule

bind exti_detector exti_checker #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .io_clk_on_i (io_clk_on_i),
    .pin_i       (pin_i),
    .sense_i     (sense_i),
    .en_i        (en_i),
    .clr_i       (clr_i),
    .irq_o       (irq_o),
    .wake_o      (wake_o)
);

// File: tb/sim_exti_detector.sv
`timescale 1ns/1ps
module sim_exti_detector;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_on = 1'b1;
    logic [1:0] pin = 2'b11;
    logic [3:0] sense = 4'b1010;
    logic [1:0] en = 2'b11;
    logic [1:0] clr = 2'b00;
    logic [1:0] irq;
    logic       wake;

    always #10 clk = ~clk;

    exti_detector u0 (
        .clk_i(clk), .rst_ni(rst_n), .io_clk_on_i(io_on), .pin_i(pin),
        .sense_i(sense), .en_i(en), .clr_i(clr), .irq_o(irq), .wake_o(wake)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string cur_req = "R10";

    // Reference history: samples taken since the clock last (re)started.
    int run [2];
    bit smp [2][3];   // smp[n][2] newest, smp[n][0] oldest
    bit flag [2];

    task automatic ref_reset();
        for (int n = 0; n < 2; n++) begin
            run[n] = 0; flag[n] = 1'b0;
        end
    endtask

    task automatic check_and_step();
        bit [1:0] e_irq;
        bit       e_wake;
        bit       lvlw;
        #1;
        lvlw = 1'b0;
        for (int n = 0; n < 2; n++) begin
            int  m;
            bit  armed;
            m     = sense[2*n +: 2];
            armed = io_on && run[n] >= 3;
            if (!en[n])      e_irq[n] = 1'b0;
            else if (m == 0) e_irq[n] = armed ? !smp[n][1] : !pin[n];
            else             e_irq[n] = flag[n];
            if (en[n] && m == 0 && !pin[n]) lvlw = 1'b1;
        end
        e_wake = (|e_irq) | lvlw;
        n_vec++;
        if (irq !== e_irq) begin
            n_bad++;
            $display("FAIL %s t=%0t irq actual=%b expected=%b", cur_req, $time, irq, e_irq);
        end
        n_vec++;
        if (wake !== e_wake) begin
            n_bad++;
            $display("FAIL R9 t=%0t wake actual=%b expected=%b", $time, wake, e_wake);
        end
        // Advance the model across the coming rising edge.
        if (!rst_n) begin
            ref_reset();
        end else begin
            for (int n = 0; n < 2; n++) begin
                int m;
                bit hit;
                m   = sense[2*n +: 2];
                hit = 1'b0;
                if (io_on) begin
                    if (run[n] >= 3 && m != 0) begin
                        bit c, o;
                        c = smp[n][1]; o = smp[n][0];
                        hit = (m == 1) ? (c != o) : (m == 2) ? (o && !c) : (c && !o);
                    end
                    smp[n][0] = smp[n][1];
                    smp[n][1] = smp[n][2];
                    smp[n][2] = pin[n];
                    if (run[n] < 3) run[n]++;
                end else begin
                    run[n] = 0;
                end
                flag[n] = hit | (flag[n] & !clr[n]);
            end
        end
        @(negedge clk);
    endtask

    task automatic cycles(int k);
        for (int i = 0; i < k; i++) check_and_step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        ref_reset();
        @(negedge clk);
        // R10: reset state with pins high
        cur_req = "R10"; cycles(4);
        rst_n = 1'b1; cycles(5);

        // R2: falling edge on line 0, then the rising edge is ignored
        cur_req = "R2";
        pin[0] = 1'b0; cycles(5);
        pin[0] = 1'b1; cycles(4);
        // R5: clear, then a set arriving on the same edge as a clear
        cur_req = "R5";
        clr[0] = 1'b1; check_and_step(); clr[0] = 1'b0; cycles(2);
        pin[0] = 1'b0; cycles(2);
        clr[0] = 1'b1; check_and_step(); clr[0] = 1'b0; cycles(4);
        clr = 2'b11; check_and_step(); clr = 2'b00; cycles(2);

        // R3: rising edge on line 1
        cur_req = "R3"; sense[3:2] = 2'b11;
        pin[1] = 1'b0; cycles(4);
        pin[1] = 1'b1; cycles(4);
        clr[1] = 1'b1; check_and_step(); clr[1] = 1'b0; cycles(2);

        // R4: any change on both lines
        cur_req = "R4"; sense = 4'b0101; pin = 2'b11; cycles(4);
        clr = 2'b11; check_and_step(); clr = 2'b00;
        pin[0] = 1'b1; pin[1] = 1'b0; cycles(4);
        clr = 2'b11; check_and_step(); clr = 2'b00;
        pin[1] = 1'b1; cycles(4);
        clr = 2'b11; check_and_step(); clr = 2'b00; cycles(3);

        // R6: flag sets while disabled, request appears on enable
        cur_req = "R6"; en = 2'b00; sense = 4'b1010;
        pin = 2'b00; cycles(5);
        en = 2'b11; cycles(2);
        clr = 2'b11; check_and_step(); clr = 2'b00;
        pin = 2'b11; cycles(4);

        // R1: low level follows the pin, no latching
        cur_req = "R1"; sense = 4'b0000;
        pin[0] = 1'b0; cycles(5);
        pin[0] = 1'b1; cycles(4);
        en[1] = 1'b0; pin[1] = 1'b0; cycles(3);
        en[1] = 1'b1; cycles(3); pin[1] = 1'b1; cycles(4);

        // R7: changes while halted raise nothing, restart windows
        cur_req = "R7"; sense = 4'b0101;
        io_on = 1'b0; cycles(2);
        pin = 2'b00; cycles(3);
        io_on = 1'b1; cycles(6);
        io_on = 1'b0; pin = 2'b11; check_and_step();
        io_on = 1'b1; check_and_step();
        pin = 2'b00; check_and_step();
        pin = 2'b11; cycles(2);
        pin = 2'b00; cycles(5);
        clr = 2'b11; check_and_step(); clr = 2'b00;
        pin = 2'b11; cycles(4);
        clr = 2'b11; check_and_step(); clr = 2'b00; cycles(2);

        // R8: asynchronous low level with the clock halted, and on restart
        cur_req = "R8"; sense = 4'b1000;
        io_on = 1'b0; cycles(2);
        pin[0] = 1'b0; cycles(3);
        pin[0] = 1'b1; check_and_step();
        io_on = 1'b1; pin[0] = 1'b0; cycles(5);
        pin[0] = 1'b1; cycles(4);

        // R9 and mixed: pseudo-random traffic, clock gated irregularly
        cur_req = "R9";
        void'($urandom(32'd7));
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom;
            pin   = r[1:0];
            if (r[4:2] == 3'd0) sense = r[11:8];
            if (r[7:5] == 3'd0) io_on = ~io_on;
            en    = (r[14:12] == 3'd0) ? r[16:15] : en;
            clr   = (r[19:17] == 3'd0) ? r[21:20] : 2'b00;
            check_and_step();
        end
        clr = 2'b00; io_on = 1'b1; cycles(4);
        finish_run();
    end
endmodule